// File: doc/BRIEF.md
# Flash Write Status Reporter

This block models how a byte-wide NOR flash reports its state while an internal program or erase is in progress. A one-cycle start pulse, together with an operation code and the byte being written, opens a busy window whose length is a fixed, parameterised number of clock cycles for each kind of operation. During that window the read-data output does not carry array contents. Bit 7 reports completion polarity, bit 6 flips once per read access, and bits 5 to 0 pass through from the array side.

When no operation is in progress, the array byte reaches the read-data output unchanged. Completion is observed by software either as bit 7 returning its true value or as bit 6 no longer changing between two reads. The command decoder that produces the start pulse, the cell array and the pads live outside this block.

Top module: `flash_wr_status`

## Requirements
- R1: After reset `busy` is 0 and `rd_data` equals `array_data`.
- R2: `op_kind` encodes 2'b00 = byte program, 2'b01 = sector erase, 2'b10 = chip erase. A `start` pulse while idle with one of these codes raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES clock cycles respectively.
- R3: A `start` pulse with `op_kind` 2'b11 is ignored, and `busy` stays 0.
- R4: A `start` pulse while busy is ignored. The running operation's length and its bit-7 report are unchanged.
- R5: While a program is busy, bit 7 of `rd_data` is the complement of bit 7 of `wr_data` as captured with the accepted `start`.
- R6: While a sector or chip erase is busy, bit 7 of `rd_data` is 0, whatever `wr_data` was.
- R7: While busy, bit 6 of `rd_data` is a toggle bit. It inverts on the clock edge that first samples a qualified read (`cs_n` and `oe_n` both 0), and a read held for several cycles inverts it once. Bits 5 to 0 of `rd_data` equal `array_data[5:0]`.
- R8: A read strobe with only one of `cs_n` or `oe_n` low does not invert the toggle bit.
- R9: The toggle bit is cleared when an operation is accepted, so the first qualified read of every operation returns bit 6 = 1.
- R10: While idle, `rd_data` equals `array_data` for every read, and reads leave it unchanged. After an erase, an all-ones array therefore reads back as 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins an internal operation |
| op_kind | input | 2 | Operation code: 00 program, 01 sector erase, 10 chip erase |
| wr_data | input | 8 | Byte being programmed, captured with `start` |
| cs_n | input | 1 | Active-low chip select of the read strobe |
| oe_n | input | 1 | Active-low output enable of the read strobe |
| array_data | input | 8 | Byte from the array at the addressed location |
| busy | output | 1 | High while an internal operation runs |
| rd_data | output | 8 | Read byte: array data when idle, status byte when busy |

## Verification
Two functions can meet in one cycle: a fresh `start` request and a running busy countdown, and likewise a read strobe and the countdown reaching its end. The bench issues a second `start` in the middle of a program with an erase code and a different data bit. It then checks that the busy length still matches the program count and that bit 7 keeps the program polarity. Reads are placed both inside the busy window and immediately after it, and bit 6 is judged against an alternation computed in the bench from the number of qualified reads issued.

// File: rtl/flash_wr_status.sv
module flash_wr_status #(
  parameter int PROG_CYCLES = 1000,
  parameter int SECT_CYCLES = 1250000,
  parameter int CHIP_CYCLES = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op_kind,
  input  logic [7:0] wr_data,
  input  logic       cs_n,
  input  logic       oe_n,
  input  logic [7:0] array_data,
  output logic       busy,
  output logic [7:0] rd_data
);

  localparam int MAXC = (CHIP_CYCLES > SECT_CYCLES)
                      ? ((CHIP_CYCLES > PROG_CYCLES) ? CHIP_CYCLES : PROG_CYCLES)
                      : ((SECT_CYCLES > PROG_CYCLES) ? SECT_CYCLES : PROG_CYCLES);
  localparam int CW = $clog2(MAXC + 1);

  localparam logic [1:0] OP_PROG = 2'b00;
  localparam logic [1:0] OP_SECT = 2'b01;
  localparam logic [1:0] OP_CHIP = 2'b10;

  logic [CW-1:0] cnt;
  logic          is_prog;
  logic          pol_bit;
  logic          tog;
  logic          rd_prev;
  logic          rd_q;
  logic          accept;
  logic [CW-1:0] dur;

  assign rd_q   = !cs_n && !oe_n;
  assign accept = start && !busy && (op_kind != 2'b11);

  always_comb begin
    unique case (op_kind)
      OP_PROG: dur = CW'(PROG_CYCLES);
      OP_SECT: dur = CW'(SECT_CYCLES);
      OP_CHIP: dur = CW'(CHIP_CYCLES);
      default: dur = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      is_prog <= 1'b0;
      pol_bit <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      cnt     <= dur;
      is_prog <= (op_kind == OP_PROG);
      pol_bit <= wr_data[7];
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog     <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      rd_prev <= rd_q;
      if (accept)                       tog <= 1'b0;
      else if (busy && rd_q && !rd_prev) tog <= ~tog;
    end
  end

  assign rd_data = busy ? {(is_prog ? ~pol_bit : 1'b0), tog, array_data[5:0]}
                        : array_data;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_kind != 2'b11) |=> busy);

  // R3
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_kind == 2'b11) |=> !busy);

  // R4
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(is_prog) && $stable(pol_bit)));

  // R6
  erase_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_prog) |-> !rd_data[7]);

  // R9
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tog);

  // R10
  idle_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(tog));

endmodule

// File: tb/tb_flash_wr_status.sv
module tb_flash_wr_status;
  localparam int PN = 12;
  localparam int SN = 30;
  localparam int CN = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic       cs_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [7:0] array_data = 8'h00;
  logic       busy;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;

  flash_wr_status #(.PROG_CYCLES(PN), .SECT_CYCLES(SN), .CHIP_CYCLES(CN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .wr_data(wr_data), .cs_n(cs_n), .oe_n(oe_n), .array_data(array_data),
    .busy(busy), .rd_data(rd_data));

  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic kick(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; op_kind = k; wr_data = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_read(input logic c, input logic o, output logic [7:0] v);
    @(negedge clk);
    cs_n = c; oe_n = o;
    @(negedge clk);
    v = rd_data;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    array_data = 8'hA5;
    #1;
    check("R1 busy", busy, 0);
    check("R1 rd_data", rd_data, 8'hA5);
  endtask

  task automatic t_program();
    logic [7:0] v;
    int n;
    array_data = 8'h2D;
    kick(2'b00, 8'h80);
    n = 1;
    check("R2 busy after start", busy, 1);
    do_read(1'b0, 1'b0, v);
    n += 2;
    check("R5 bit7", v[7], 0);
    check("R9 first read bit6", v[6], 1);
    check("R7 low bits", v[5:0], 6'h2D);
    do_read(1'b0, 1'b0, v);
    n += 2;
    check("R7 second read bit6", v[6], 0);
    do_read(1'b0, 1'b0, v);
    n += 2;
    check("R7 third read bit6", v[6], 1);
    begin
      int m;
      wait_idle(m);
      n += m - 1;
    end
    check("R2 program length", n, PN);
  endtask

  task automatic t_program_pol();
    logic [7:0] v;
    int n;
    array_data = 8'h00;
    kick(2'b00, 8'h11);
    do_read(1'b0, 1'b0, v);
    check("R5 bit7 complement of 0", v[7], 1);
    check("R9 toggle cleared on new op", v[6], 1);
    wait_idle(n);
  endtask

  task automatic t_erase(input logic [1:0] k, input int exp_len, input string tag);
    logic [7:0] v;
    int n;
    array_data = 8'h95;
    kick(k, 8'h00);
    n = 1;
    do_read(1'b0, 1'b0, v);
    n += 2;
    check({"R6 bit7 ", tag}, v[7], 0);
    check({"R9 bit6 ", tag}, v[6], 1);
    check({"R7 low bits ", tag}, v[5:0], 6'h15);
    begin
      int m;
      wait_idle(m);
      n += m - 1;
    end
    check({"R2 length ", tag}, n, exp_len);
    array_data = 8'hFF;
    do_read(1'b0, 1'b0, v);
    check({"R10 erased reads FF ", tag}, v, 8'hFF);
  endtask

  task automatic t_held_and_unqualified();
    logic [7:0] v;
    int n;
    array_data = 8'h00;
    kick(2'b01, 8'h00);
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    v = rd_data;
    cs_n = 1'b1; oe_n = 1'b1;
    check("R7 held read flips once", v[6], 1);
    do_read(1'b1, 1'b0, v);
    check("R8 oe only no flip", v[6], 1);
    do_read(1'b0, 1'b1, v);
    check("R8 cs only no flip", v[6], 1);
    do_read(1'b0, 1'b0, v);
    check("R7 qualified read flips", v[6], 0);
    wait_idle(n);
  endtask

  task automatic t_restart_ignored();
    logic [7:0] v;
    int n;
    array_data = 8'h00;
    kick(2'b00, 8'h00);
    n = 1;
    repeat (3) @(negedge clk);
    n += 3;
    start = 1'b1; op_kind = 2'b10; wr_data = 8'hFF;
    @(negedge clk);
    n += 1;
    start = 1'b0;
    check("R4 bit7 keeps program polarity", rd_data[7], 1);
    begin
      int m;
      wait_idle(m);
      n += m - 1;
    end
    check("R4 length unchanged", n, PN);
  endtask

  task automatic t_bad_code();
    kick(2'b11, 8'h00);
    check("R3 busy stays low", busy, 0);
    @(negedge clk);
    check("R3 busy still low", busy, 0);
  endtask

  task automatic t_idle_reads();
    logic [7:0] v;
    array_data = 8'h40;
    do_read(1'b0, 1'b0, v);
    check("R10 idle read 1", v, 8'h40);
    do_read(1'b0, 1'b0, v);
    check("R10 idle read 2", v, 8'h40);
    array_data = 8'h3C;
    #1;
    check("R10 idle follows array", rd_data, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_reads();
    t_program();
    t_program_pol();
    t_erase(2'b01, SN, "sector");
    t_erase(2'b10, CN, "chip");
    t_held_and_unqualified();
    t_restart_ignored();
    t_bad_code();
    t_idle_reads();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule